// File: doc/BRIEF.md
# Serial Channel Interrupt Flag Logic

This block gathers the completion and error events of one serial channel into interrupt factors. The transmitter and receiver send it single-cycle pulses: transmit done, receive done, parity error, framing error and overrun error. From these it keeps three sticky factor flags: transmit complete, receive complete and a shared error factor. Each factor has its own mask bit. A second set of sticky flags records which kind of error happened, because all three error kinds feed the same error factor.

One registered interrupt request goes to the CPU. It is high when any factor flag is set together with its mask bit, and only while the global interrupt-enable input is high. Software uses a small register port to read the flags, to clear them by writing 1, and to read and write the masks. A parity or framing error also marks the received byte as complete, so software reads and discards it. An overrun error does not mark a byte as complete.

Top module: `serial_irq_ctrl`

## Requirements
- R1: A `tx_done_i` pulse sets the transmit factor, bit 0 of address 0, on the following clock edge.
- R2: A `rx_done_i`, `par_err_i` or `frm_err_i` pulse sets the receive factor, bit 1 of address 0. An `ovr_err_i` pulse alone leaves it unchanged.
- R3: Any of `par_err_i`, `ovr_err_i` or `frm_err_i` sets the error factor, bit 2 of address 0.
- R4: The error-type flags at address 2 record the cause: bit 0 for parity, bit 1 for overrun, bit 2 for framing. Each is sticky.
- R5: Factor flags are set by their events whatever the value of the mask bits.
- R6: `irq_o` is registered. It is high one cycle after some factor flag and its mask bit are both 1 while `gie_i` is 1, and low otherwise.
- R7: Writing 1 to a bit at address 0 or address 2 clears that flag. Writing 0 leaves it unchanged.
- R8: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: Address 1 holds the three mask bits, in the same bit positions as the factors, and can be read and written. Address 3 reads as 0 and ignores writes.
- R10: After reset every flag, every mask bit and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_done_i | input | 1 | Transmit shift finished (pulse) |
| rx_done_i | input | 1 | Received byte moved to the buffer (pulse) |
| par_err_i | input | 1 | Parity error detected (pulse) |
| ovr_err_i | input | 1 | Overrun error detected (pulse) |
| frm_err_i | input | 1 | Framing error detected (pulse) |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 3 | Write data |
| rdata_o | output | 3 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume the event inputs and `gie_i` are driven to a known 0 or 1 on every clock. They also assume `addr_i` and `wdata_i` are known whenever `wr_en_i` is high. They do not assume the event pulses are one-hot: several may arrive in the same cycle. The stimulus changes inputs only on the falling edge. It mixes events together, sends some events while their masks are off, and places set events in the same cycle as clearing writes, so that the priority rule is exercised.

// File: rtl/serial_irq_pkg.sv
// Package: shared widths and bit positions for the serial interrupt flag logic.
// Assumes: nothing; constants only.
package serial_irq_pkg;
    localparam int FACT_W = 3;   // number of factor flags
    localparam int ERR_W  = 3;   // number of error-type flags
    localparam int ADDR_W = 2;   // register address width
    localparam int DATA_W = (FACT_W > ERR_W) ? FACT_W : ERR_W;

    // factor bit positions
    localparam int F_TX  = 0;
    localparam int F_RX  = 1;
    localparam int F_ERR = 2;

    // error-type bit positions
    localparam int E_PAR = 0;
    localparam int E_OVR = 1;
    localparam int E_FRM = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FACT = 2'd0,
        REG_MASK = 2'd1,
        REG_ETYP = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_w1c_bank.sv
// Bank of sticky flags. A set pulse sets a bit, and a write-1 clears it.
// If set and clear arrive on the same bit together, set has priority.
// Assumes: set_i and clr_i are already qualified by the caller.
module irq_w1c_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // one sticky bit: reset, then set over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Plain read/write mask register, loaded when wr_i is high.
// Assumes: the write strobe is already decoded for this register.
module irq_mask_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // hold the mask value, load it on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (wr_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/irq_req_gen.sv
// Interrupt request generator. It ORs together the factor flags that are
// enabled by the mask, gates the result with the global enable, and
// registers it.
// Assumes: the flag and mask inputs come straight from registers.
module irq_req_gen #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flag_i,
    input  logic [W-1:0] mask_i,
    input  logic         gie_i,
    output logic         irq_o
);
    logic any_live;

    // combine the flags that are enabled by the mask
    always_comb any_live = |(flag_i & mask_i);

    // register the gated request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= any_live & gie_i;
    end
endmodule

// File: rtl/serial_irq_ctrl.sv
// Top level of the interrupt flag logic for one serial channel.
// It turns the channel's event pulses into sticky factor flags and
// sticky error-type flags, and drives one registered interrupt request.
// Register port: address 0 holds the factors (write 1 to clear),
// address 1 the masks, address 2 the error types (write 1 to clear),
// and address 3 is unused.
// Assumes: event inputs are pulses synchronous to clk.
module serial_irq_ctrl
    import serial_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_done_i,
    input  logic              rx_done_i,
    input  logic              par_err_i,
    input  logic              ovr_err_i,
    input  logic              frm_err_i,
    input  logic              gie_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    logic [FACT_W-1:0] fact_set, fact_clr, factor_q, mask_q;
    logic [ERR_W-1:0]  etyp_set, etyp_clr, etyp_q;
    logic              any_err, wr_fact, wr_mask, wr_etyp;

    // decode the register writes
    always_comb begin
        wr_fact = wr_en_i && (addr_i == REG_FACT);
        wr_mask = wr_en_i && (addr_i == REG_MASK);
        wr_etyp = wr_en_i && (addr_i == REG_ETYP);
    end

    // map the events onto set vectors and the writes onto clear vectors
    always_comb begin
        any_err         = par_err_i | ovr_err_i | frm_err_i;
        fact_set        = '0;
        fact_set[F_TX]  = tx_done_i;
        fact_set[F_RX]  = rx_done_i | par_err_i | frm_err_i;
        fact_set[F_ERR] = any_err;
        etyp_set        = '0;
        etyp_set[E_PAR] = par_err_i;
        etyp_set[E_OVR] = ovr_err_i;
        etyp_set[E_FRM] = frm_err_i;
        fact_clr        = wr_fact ? wdata_i[FACT_W-1:0] : '0;
        etyp_clr        = wr_etyp ? wdata_i[ERR_W-1:0]  : '0;
    end

    irq_w1c_bank #(.W(FACT_W)) u_fact (
        .clk(clk), .rst_n(rst_n), .set_i(fact_set), .clr_i(fact_clr), .q_o(factor_q)
    );

    irq_w1c_bank #(.W(ERR_W)) u_etyp (
        .clk(clk), .rst_n(rst_n), .set_i(etyp_set), .clr_i(etyp_clr), .q_o(etyp_q)
    );

    irq_mask_reg #(.W(FACT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_mask), .d_i(wdata_i[FACT_W-1:0]), .q_o(mask_q)
    );

    irq_req_gen #(.W(FACT_W)) u_req (
        .clk(clk), .rst_n(rst_n), .flag_i(factor_q), .mask_i(mask_q),
        .gie_i(gie_i), .irq_o(irq_o)
    );

    // read multiplexer
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_FACT: rdata_o[FACT_W-1:0] = factor_q;
            REG_MASK: rdata_o[FACT_W-1:0] = mask_q;
            REG_ETYP: rdata_o[ERR_W-1:0]  = etyp_q;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/serial_irq_chk.sv
// Checker for serial_irq_ctrl, attached with bind. It watches the ports and
// the flag and mask registers of the top module.
// Assumes: the inputs are known on every clock edge after reset.
module serial_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_done_i,
    input logic       rx_done_i,
    input logic       par_err_i,
    input logic       ovr_err_i,
    input logic       frm_err_i,
    input logic       gie_i,
    input logic       wr_en_i,
    input logic [1:0] addr_i,
    input logic [2:0] wdata_i,
    input logic [2:0] rdata_o,
    input logic [2:0] factor_q,
    input logic [2:0] mask_q,
    input logic [2:0] etyp_q,
    input logic       irq_o
);
    // R1
    tx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> factor_q[0]);
    // R2
    rx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i || par_err_i || frm_err_i) |=> factor_q[1]);
    // R2
    ovr_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err_i && !rx_done_i && !par_err_i && !frm_err_i && !factor_q[1]) |=> !factor_q[1]);
    // R3
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_i || ovr_err_i || frm_err_i) |=> factor_q[2]);
    // R4
    ovr_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err_i |=> etyp_q[1]);
    // R6
    irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(factor_q & mask_q)) && gie_i) |=> irq_o);
    // R6
    irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |=> !irq_o);
    // R7
    w1c_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0 && wdata_i[0] && !tx_done_i) |=> !factor_q[0]);
    // R7
    hold_fact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !tx_done_i && !rx_done_i && !par_err_i && !ovr_err_i && !frm_err_i)
        |=> $stable(factor_q) && $stable(etyp_q));
    // R9
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 2'd3) |-> (rdata_o == 3'd0));
    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == 2'd1) |=> $stable(mask_q));
endmodule

bind serial_irq_ctrl serial_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
    .par_err_i(par_err_i), .ovr_err_i(ovr_err_i), .frm_err_i(frm_err_i),
    .gie_i(gie_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .factor_q(factor_q), .mask_q(mask_q), .etyp_q(etyp_q),
    .irq_o(irq_o)
);

// File: tb/tb_serial_irq_ctrl.sv
module tb_serial_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_done_i = 1'b0, rx_done_i = 1'b0, par_err_i = 1'b0;
    logic       ovr_err_i = 1'b0, frm_err_i = 1'b0, gie_i = 1'b0, wr_en_i = 1'b0;
    logic [1:0] addr_i = 2'd0;
    logic [2:0] wdata_i = 3'd0;
    logic [2:0] rdata_o;
    logic       irq_o;

    int    checks = 0;
    int    errors = 0;
    string phase = "R10 reset";

    // behavioural reference state, held as integers
    int m_fact[3];
    int m_mask[3];
    int m_etyp[3];
    int m_irq;

    always #5 clk = ~clk;

    serial_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done_i), .rx_done_i(rx_done_i),
        .par_err_i(par_err_i), .ovr_err_i(ovr_err_i), .frm_err_i(frm_err_i),
        .gie_i(gie_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // reference model: advances once per rising edge
    always @(posedge clk) begin
        int live;
        int sets_f[3];
        int sets_e[3];
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_fact[i] = 0; m_mask[i] = 0; m_etyp[i] = 0;
            end
            m_irq = 0;
        end else begin
            live = 0;
            for (int i = 0; i < 3; i++)
                if (m_fact[i] == 1 && m_mask[i] == 1) live = 1;
            m_irq = (live == 1 && gie_i) ? 1 : 0;
            sets_f[0] = tx_done_i;
            sets_f[1] = (rx_done_i || par_err_i || frm_err_i) ? 1 : 0;
            sets_f[2] = (par_err_i || ovr_err_i || frm_err_i) ? 1 : 0;
            sets_e[0] = par_err_i;
            sets_e[1] = ovr_err_i;
            sets_e[2] = frm_err_i;
            for (int i = 0; i < 3; i++) begin
                if (sets_f[i] == 1) m_fact[i] = 1;
                else if (wr_en_i && addr_i == 2'd0 && wdata_i[i]) m_fact[i] = 0;
                if (sets_e[i] == 1) m_etyp[i] = 1;
                else if (wr_en_i && addr_i == 2'd2 && wdata_i[i]) m_etyp[i] = 0;
                if (wr_en_i && addr_i == 2'd1) m_mask[i] = wdata_i[i];
            end
        end
    end

    function automatic logic [2:0] exp_read(input logic [1:0] a);
        logic [2:0] v = 3'd0;
        for (int i = 0; i < 3; i++) begin
            if (a == 2'd0) v[i] = m_fact[i][0];
            if (a == 2'd1) v[i] = m_mask[i][0];
            if (a == 2'd2) v[i] = m_etyp[i][0];
        end
        return v;
    endfunction

    // compare the outputs with the model on every falling edge
    always @(negedge clk) begin
        logic [2:0] er;
        if (rst_n) begin
            er = exp_read(addr_i);
            checks++;
            if (rdata_o !== er) begin
                errors++;
                $display("FAIL %s: rdata addr %0d actual %b expected %b", phase, addr_i, rdata_o, er);
            end
            checks++;
            if (irq_o !== m_irq[0]) begin
                errors++;
                $display("FAIL %s: irq actual %b expected %b", phase, irq_o, m_irq[0]);
            end
        end
    end

    // drive the inputs for one cycle just after the falling edge, then wait
    task automatic step(input logic tx, rx, pe, oe, fe, we, input logic [1:0] a,
                        input logic [2:0] d);
        @(negedge clk); #1;
        tx_done_i = tx; rx_done_i = rx; par_err_i = pe; ovr_err_i = oe; frm_err_i = fe;
        wr_en_i = we; addr_i = a; wdata_i = d;
    endtask

    task automatic idle(input logic [1:0] a);
        step(0, 0, 0, 0, 0, 0, a, 3'd0);
    endtask

    task automatic sweep();
        idle(2'd0); idle(2'd1); idle(2'd2); idle(2'd3);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1;
        // R10 reset state seen on every register and on irq
        phase = "R10 reset"; sweep();
        // R1 and R5: transmit done with its mask off
        phase = "R1 R5 tx masked"; step(1, 0, 0, 0, 0, 0, 2'd0, 3'd0); sweep();
        // R6: enable the mask without gie, then with gie
        phase = "R6 mask no gie"; step(0, 0, 0, 0, 0, 1, 2'd1, 3'b001); sweep();
        phase = "R6 gie on"; gie_i = 1; sweep(); gie_i = 0; idle(2'd0);
        gie_i = 1;
        // R7: write 0 does nothing, write 1 clears
        phase = "R7 write zero"; step(0, 0, 0, 0, 0, 1, 2'd0, 3'b000); sweep();
        phase = "R7 write one"; step(0, 0, 0, 0, 0, 1, 2'd0, 3'b001); sweep();
        // R2: receive done alone
        phase = "R2 rx done"; step(0, 1, 0, 0, 0, 0, 2'd0, 3'd0); sweep();
        step(0, 0, 0, 0, 0, 1, 2'd0, 3'b111); sweep();
        // R2 R3 R4: overrun alone does not set rx
        phase = "R2 R3 R4 overrun"; step(0, 0, 0, 1, 0, 0, 2'd0, 3'd0); sweep();
        step(0, 0, 0, 0, 0, 1, 2'd0, 3'b111); step(0, 0, 0, 0, 0, 1, 2'd2, 3'b111); sweep();
        // R2 R3 R4: parity error
        phase = "R2 R3 R4 parity"; step(0, 0, 1, 0, 0, 0, 2'd0, 3'd0); sweep();
        // R2 R3 R4: framing error, then clear types one at a time
        phase = "R2 R3 R4 framing"; step(0, 0, 0, 0, 1, 0, 2'd0, 3'd0); sweep();
        phase = "R7 type clear"; step(0, 0, 0, 0, 0, 1, 2'd2, 3'b001); sweep();
        step(0, 0, 0, 0, 0, 1, 2'd2, 3'b100); sweep();
        // R6: error factor raises irq once its mask is on
        phase = "R6 error mask"; step(0, 0, 0, 0, 0, 1, 2'd1, 3'b100); sweep();
        step(0, 0, 0, 0, 0, 1, 2'd0, 3'b111); sweep();
        // R8: set and clear on the same cycle, the set wins
        phase = "R8 tx race"; step(1, 0, 0, 0, 0, 1, 2'd0, 3'b001); sweep();
        phase = "R8 type race"; step(0, 0, 0, 1, 0, 1, 2'd2, 3'b010); sweep();
        // R9: mask readback and the unused address
        phase = "R9 mask rw"; step(0, 0, 0, 0, 0, 1, 2'd1, 3'b110); sweep();
        phase = "R9 unused addr"; step(0, 0, 0, 0, 0, 1, 2'd3, 3'b111); sweep();
        // R5: all events at once with every mask off
        phase = "R5 all masked"; step(0, 0, 0, 0, 0, 1, 2'd1, 3'b000);
        step(1, 1, 1, 1, 1, 0, 2'd0, 3'd0); sweep();
        // a mixed pattern of events and writes
        phase = "R1 R2 R3 mixed";
        for (int k = 0; k < 40; k++) begin
            logic [7:0] v = 8'(k * 37 + 11);
            step(v[0], v[1], v[2] & v[5], v[3] & v[6], v[4] & v[7], v[5], v[7:6], v[2:0]);
        end
        sweep();
        // R10: a second reset clears everything
        phase = "R10 re-reset"; @(negedge clk); #1; rst_n = 1'b0;
        @(negedge clk); #1; rst_n = 1'b1; sweep();
        finish_run();
    end
endmodule